// File: doc/BRIEF.md
# Board Interrupt Expander with Register Bank

This block sits in a debug board's programmable logic and funnels up to sixteen peripheral interrupt sources into a single active-low, level-sensitive request line to the host processor. Each source is brought into the clock domain through a two-flop synchroniser. A rising edge on a source latches a sticky bit in the pending-status register. A host-programmed mask, in which a set bit disables its source, decides which latched bits may pull the request line low. Bit 0 carries the Ethernet controller, bits 1 and 2 the two external UARTs, and bits 3 and 4 the two push buttons. The remaining bits are spare inputs.

The host reaches the block over a simple synchronous bus with byte offsets and 16-bit data. To acknowledge a source, the host writes a one to that bit of the clear register and then writes the register back to zero. While a clear bit holds a one, the matching status bit is forced low. The same bank also provides a fixed three-word signature that lets software probe for the board, a firmware version word, a board identity word, an LED output register, a synchronised button input register, and a module-reset register whose bits drive active-high reset lines to the peripherals.

The request line is produced by a two-state machine. `IRQ_IDLE` moves to `IRQ_ASSERT` when any status bit is set while its mask bit is clear (transition "raise"). `IRQ_ASSERT` returns to `IRQ_IDLE` once no such bit remains (transition "drop"). Each state otherwise holds. The output `irq_n` is low exactly in `IRQ_ASSERT`.

Top module: `cpld_irq_expander`

## Requirements
- R1: After reset, the mask register (offset 0x38) reads 0xFFFF, the status register (0x10) and the clear register (0x20) read 0x0000, the LED (0x00) and module-reset (0x60) registers read 0x0000, `mod_rst` is 0 and `irq_n` is 1.
- R2: A rising edge on `src_in[i]` sets status bit i three clock edges after the input changes (two synchroniser flops plus the status flop). The bit stays set after the source falls. Several sources may be set at once, and each lands on its own bit.
- R3: Writing value V to the clear register stores V and reads it back. On every clock edge while bit i of the clear register is 1, status bit i is cleared. Once the register is written back to zero, a cleared bit stays 0 until a new rising edge arrives.
- R4: When a synchronised rising edge and a held clear bit meet at the same clock edge, the status bit is set. It is cleared at the next edge if the clear bit is still held.
- R5: The mask register is read/write, and a 1 disables its source. `irq_n` goes low one clock edge after some bit is set in status and clear in mask. It stays low while such a bit remains, and returns high one edge after none remains.
- R6: Reads return 0xAAAA at 0x40, 0x5555 at 0x48 and 0xCAFE at 0x58. The version parameter is returned at 0x50 and the board-identity parameter at 0x68.
- R7: The LED register (0x00) and the module-reset register (0x60) are read/write. Each bit of the module-reset register drives `mod_rst` and holds its value until the register is rewritten.
- R8: Offset 0x08 returns `btn_in` after a two-flop synchroniser.
- R9: Reads from unmapped offsets return 0x0000, and reads when the bus is idle return 0x0000. Writes to unmapped offsets, and to the status, signature, version and identity registers, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the offset |
| src_in | input | 16 | Asynchronous interrupt sources, one per bit |
| btn_in | input | 16 | Asynchronous button levels |
| led_out | output | 16 | LED register contents |
| mod_rst | output | 16 | Active-high peripheral reset lines |
| irq_n | output | 1 | Active-low level interrupt request to the host |

## Verification
Sources are pulsed one at a time and in a group (pattern 0x0015), so that a wrong bit mapping or a level-triggered latch shows up as wrong or missing status bits after the source falls. A raised source is watched under the all-disabled reset mask, then with its bit unmasked, then masked again. This separates the mask polarity and the one-edge request latency from plain status setting. A source edge timed to coincide with a held clear bit exposes which of set and clear wins. Writes to read-only and unmapped offsets, each followed by read-back, show that such writes are ignored.

// File: rtl/cpld_irq_pkg.sv
package cpld_irq_pkg;
    localparam int DW     = 16;
    localparam int AW     = 8;

    localparam logic [AW-1:0] OFS_LED    = 8'h00;
    localparam logic [AW-1:0] OFS_BTN    = 8'h08;
    localparam logic [AW-1:0] OFS_STAT   = 8'h10;
    localparam logic [AW-1:0] OFS_CLR    = 8'h20;
    localparam logic [AW-1:0] OFS_MASK   = 8'h38;
    localparam logic [AW-1:0] OFS_SIG_A  = 8'h40;
    localparam logic [AW-1:0] OFS_SIG_B  = 8'h48;
    localparam logic [AW-1:0] OFS_VER    = 8'h50;
    localparam logic [AW-1:0] OFS_SIG_C  = 8'h58;
    localparam logic [AW-1:0] OFS_MRST   = 8'h60;
    localparam logic [AW-1:0] OFS_ID     = 8'h68;

    localparam logic [DW-1:0] SIG_A_WORD = 16'hAAAA;
    localparam logic [DW-1:0] SIG_B_WORD = 16'h5555;
    localparam logic [DW-1:0] SIG_C_WORD = 16'hCAFE;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ASSERT = 1'b1
    } irq_state_t;
endpackage

// File: rtl/cpld_sync2.sv
module cpld_sync2 #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_in[g];
                stab_q <= meta_q;
            end
        end
        assign sync_out[g] = stab_q;
    end
endmodule

// File: rtl/cpld_irq_core.sv
module cpld_irq_core
    import cpld_irq_pkg::*;
#(
    parameter int NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_lvl,
    input  logic            wr_mask,
    input  logic            wr_clr,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] status_q,
    output logic [NSRC-1:0] mask_q,
    output logic [NSRC-1:0] clr_q,
    output logic            irq_n
);
    logic [NSRC-1:0] lvl_prev_q;
    logic [NSRC-1:0] rise;
    logic            pending;
    irq_state_t      state_q, state_nx;

    assign rise    = src_lvl & ~lvl_prev_q;
    assign pending = |(status_q & ~mask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_prev_q <= '0;
            status_q   <= '0;
            mask_q     <= '1;
            clr_q      <= '0;
        end else begin
            lvl_prev_q <= src_lvl;
            // a fresh edge outranks a held clear bit
            status_q   <= (status_q & ~clr_q) | rise;
            if (wr_mask) mask_q <= wdata;
            if (wr_clr)  clr_q  <= wdata;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending)  state_nx = IRQ_ASSERT;
            IRQ_ASSERT: if (!pending) state_nx = IRQ_IDLE;
            default:    state_nx = IRQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            IRQ_ASSERT: irq_n = 1'b0;
            default:    irq_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/cpld_reg_decode.sv
module cpld_reg_decode
    import cpld_irq_pkg::*;
#(
    parameter int            NSRC    = 16,
    parameter logic [DW-1:0] VERSION = 16'h0102,
    parameter logic [DW-1:0] BOARD   = 16'h0051
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_en,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [DW-1:0]   btn_lvl,
    input  logic [NSRC-1:0] status,
    input  logic [NSRC-1:0] mask,
    input  logic [NSRC-1:0] clr,
    output logic            wr_mask,
    output logic            wr_clr,
    output logic [DW-1:0]   led_q,
    output logic [DW-1:0]   mrst_q
);
    logic wr_hit;
    logic [DW-1:0] stat_w, mask_w, clr_w;

    assign wr_hit  = bus_en && bus_we;
    assign wr_mask = wr_hit && (bus_addr == OFS_MASK);
    assign wr_clr  = wr_hit && (bus_addr == OFS_CLR);

    always_comb begin
        stat_w = '0;
        mask_w = '0;
        clr_w  = '0;
        stat_w[NSRC-1:0] = status;
        mask_w[NSRC-1:0] = mask;
        clr_w[NSRC-1:0]  = clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_q  <= '0;
            mrst_q <= '0;
        end else if (wr_hit) begin
            if (bus_addr == OFS_LED)  led_q  <= bus_wdata;
            if (bus_addr == OFS_MRST) mrst_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            case (bus_addr)
                OFS_LED:   bus_rdata = led_q;
                OFS_BTN:   bus_rdata = btn_lvl;
                OFS_STAT:  bus_rdata = stat_w;
                OFS_CLR:   bus_rdata = clr_w;
                OFS_MASK:  bus_rdata = mask_w;
                OFS_SIG_A: bus_rdata = SIG_A_WORD;
                OFS_SIG_B: bus_rdata = SIG_B_WORD;
                OFS_VER:   bus_rdata = VERSION;
                OFS_SIG_C: bus_rdata = SIG_C_WORD;
                OFS_MRST:  bus_rdata = mrst_q;
                OFS_ID:    bus_rdata = BOARD;
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cpld_irq_expander.sv
module cpld_irq_expander
    import cpld_irq_pkg::*;
#(
    parameter int            NSRC    = 16,
    parameter logic [DW-1:0] VERSION = 16'h0102,
    parameter logic [DW-1:0] BOARD   = 16'h0051
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] src_in,
    input  logic [DW-1:0] btn_in,
    output logic [DW-1:0] led_out,
    output logic [DW-1:0] mod_rst,
    output logic          irq_n
);
    logic [DW-1:0]   src_lvl;
    logic [DW-1:0]   btn_lvl;
    logic [NSRC-1:0] status_q, mask_q, clr_q;
    logic            wr_mask, wr_clr;

    cpld_sync2 #(.W(DW)) u_src_sync (
        .clk(clk), .rst_n(rst_n), .async_in(src_in), .sync_out(src_lvl)
    );

    cpld_sync2 #(.W(DW)) u_btn_sync (
        .clk(clk), .rst_n(rst_n), .async_in(btn_in), .sync_out(btn_lvl)
    );

    cpld_irq_core #(.NSRC(NSRC)) u_core (
        .clk(clk), .rst_n(rst_n),
        .src_lvl(src_lvl[NSRC-1:0]),
        .wr_mask(wr_mask), .wr_clr(wr_clr),
        .wdata(bus_wdata[NSRC-1:0]),
        .status_q(status_q), .mask_q(mask_q), .clr_q(clr_q),
        .irq_n(irq_n)
    );

    cpld_reg_decode #(.NSRC(NSRC), .VERSION(VERSION), .BOARD(BOARD)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .btn_lvl(btn_lvl),
        .status(status_q), .mask(mask_q), .clr(clr_q),
        .wr_mask(wr_mask), .wr_clr(wr_clr),
        .led_q(led_out), .mrst_q(mod_rst)
    );
endmodule

// File: rtl/cpld_irq_checker.sv
module cpld_irq_checker
    import cpld_irq_pkg::*;
#(
    parameter int NSRC = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_en,
    input logic            bus_we,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic [DW-1:0]   bus_rdata,
    input logic [DW-1:0]   mod_rst,
    input logic            irq_n,
    input logic [NSRC-1:0] status,
    input logic [NSRC-1:0] mask,
    input logic [NSRC-1:0] clr
);
    // R1 / R5: nothing pending means the request line is released next edge
    p_quiet_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |=> irq_n);

    // R5: an unmasked pending bit pulls the line low on the next edge
    p_pending_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & ~mask)) |=> !irq_n);

    // R5: mask register takes the written value
    p_mask_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == OFS_MASK) |=> (mask == $past(bus_wdata[NSRC-1:0])));

    // R2 / R4: a set bit with no clear held stays set
    p_status_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(status & ~clr)) == $past(status & ~clr)));

    // R6: signature word
    p_signature_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == OFS_SIG_C) |-> (bus_rdata == 16'hCAFE));

    // R7: reset lines hold unless their register is written
    p_mrst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && bus_we && bus_addr == OFS_MRST) |=> $stable(mod_rst));

    // R9: idle bus reads zero
    p_idle_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> (bus_rdata == '0));
endmodule

bind cpld_irq_expander cpld_irq_checker #(.NSRC(NSRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mod_rst(mod_rst), .irq_n(irq_n),
    .status(status_q), .mask(mask_q), .clr(clr_q)
);

// File: tb/cpld_irq_expander_test.sv
module cpld_irq_expander_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] src_in = '0;
    logic [15:0] btn_in = '0;
    logic [15:0] led_out;
    logic [15:0] mod_rst;
    logic        irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    cpld_irq_expander uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .btn_in(btn_in), .led_out(led_out),
        .mod_rst(mod_rst), .irq_n(irq_n)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic ack(input logic [15:0] bits);
        wr(8'h20, bits);
        wr(8'h20, 16'h0000);
    endtask

    task automatic t_reset_state();
        logic [15:0] v;
        rd(8'h38, v); check("R1 mask", v, 16'hFFFF);
        rd(8'h10, v); check("R1 status", v, 16'h0000);
        rd(8'h20, v); check("R1 clear", v, 16'h0000);
        rd(8'h00, v); check("R1 led", v, 16'h0000);
        rd(8'h60, v); check("R1 modrst reg", v, 16'h0000);
        check("R1 mod_rst pin", mod_rst, 16'h0000);
        check("R1 irq_n", {15'd0, irq_n}, 16'h0001);
    endtask

    task automatic t_latch();
        logic [15:0] v;
        @(negedge clk); src_in = 16'h0001;
        wait_clks(2);
        rd(8'h10, v); check("R2 set after three edges", v, 16'h0001);
        src_in = 16'h0000;
        wait_clks(4);
        rd(8'h10, v); check("R2 sticky after fall", v, 16'h0001);
        check("R5 masked source keeps irq_n high", {15'd0, irq_n}, 16'h0001);
        ack(16'h0001);
        rd(8'h10, v); check("R3 cleared", v, 16'h0000);
        @(negedge clk); src_in = 16'h0015;
        wait_clks(4);
        rd(8'h10, v); check("R2 group pattern", v, 16'h0015);
        src_in = 16'h0000;
        wait_clks(3);
        ack(16'h0004);
        rd(8'h10, v); check("R3 selective clear", v, 16'h0011);
        ack(16'h0011);
        rd(8'h10, v); check("R3 stays clear", v, 16'h0000);
    endtask

    task automatic t_clear_reg();
        logic [15:0] v;
        wr(8'h20, 16'h5A00);
        rd(8'h20, v); check("R3 clear readback", v, 16'h5A00);
        wr(8'h20, 16'h0000);
    endtask

    task automatic t_mask_irq();
        logic [15:0] v;
        @(negedge clk); src_in = 16'h0004;
        wait_clks(5);
        check("R5 disabled by mask", {15'd0, irq_n}, 16'h0001);
        wr(8'h38, 16'hFFFB);
        rd(8'h38, v); check("R5 mask readback", v, 16'hFFFB);
        check("R5 irq_n low after unmask", {15'd0, irq_n}, 16'h0000);
        wait_clks(3);
        check("R5 level held", {15'd0, irq_n}, 16'h0000);
        wr(8'h38, 16'hFFFF);
        wait_clks(1);
        check("R5 irq_n high after remask", {15'd0, irq_n}, 16'h0001);
        wr(8'h38, 16'h0000);
        wait_clks(1);
        check("R5 low again", {15'd0, irq_n}, 16'h0000);
        src_in = 16'h0000;
        ack(16'h0004);
        wait_clks(1);
        check("R5 released after clear", {15'd0, irq_n}, 16'h0001);
        wr(8'h38, 16'hFFFF);
    endtask

    task automatic t_set_wins();
        logic [15:0] v;
        wr(8'h20, 16'h0002);
        @(negedge clk); src_in = 16'h0002;
        wait_clks(2);
        rd(8'h10, v); check("R4 set beats clear", v, 16'h0002);
        rd(8'h10, v); check("R4 then cleared while held", v, 16'h0000);
        src_in = 16'h0000;
        wr(8'h20, 16'h0000);
    endtask

    task automatic t_ident();
        logic [15:0] v;
        rd(8'h40, v); check("R6 sig a", v, 16'hAAAA);
        rd(8'h48, v); check("R6 sig b", v, 16'h5555);
        rd(8'h58, v); check("R6 sig c", v, 16'hCAFE);
        rd(8'h50, v); check("R6 version", v, 16'h0102);
        rd(8'h68, v); check("R6 board", v, 16'h0051);
    endtask

    task automatic t_led_rst();
        logic [15:0] v;
        wr(8'h00, 16'hA5A5);
        rd(8'h00, v); check("R7 led", v, 16'hA5A5);
        check("R7 led pin", led_out, 16'hA5A5);
        wr(8'h60, 16'h0003);
        check("R7 mod_rst pin", mod_rst, 16'h0003);
        wait_clks(4);
        rd(8'h60, v); check("R7 mod_rst held", v, 16'h0003);
        wr(8'h60, 16'h0000);
        check("R7 mod_rst released", mod_rst, 16'h0000);
    endtask

    task automatic t_buttons();
        logic [15:0] v;
        @(negedge clk); btn_in = 16'h1234;
        wait_clks(2);
        rd(8'h08, v); check("R8 buttons", v, 16'h1234);
    endtask

    task automatic t_ignored();
        logic [15:0] v;
        wr(8'h40, 16'h0000);
        rd(8'h40, v); check("R9 sig write ignored", v, 16'hAAAA);
        wr(8'h10, 16'hFFFF);
        rd(8'h10, v); check("R9 status write ignored", v, 16'h0000);
        rd(8'h30, v); check("R9 unmapped read", v, 16'h0000);
        wr(8'h30, 16'h00FF);
        rd(8'h00, v); check("R9 unmapped write led", v, 16'hA5A5);
        rd(8'h38, v); check("R9 unmapped write mask", v, 16'hFFFF);
        check("R9 unmapped write modrst", mod_rst, 16'h0000);
        wr(8'h50, 16'h0000);
        rd(8'h50, v); check("R9 version write ignored", v, 16'h0102);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        wait_clks(3);
        rst_n = 1'b1;
        wait_clks(1);
        t_reset_state();
        t_latch();
        t_clear_reg();
        t_mask_irq();
        t_set_wins();
        t_ident();
        t_led_rst();
        t_buttons();
        t_ignored();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule